// File: doc/BRIEF.md
# Counter Bank Global Control Unit

This unit supervises a bank of general-purpose event counters and a bank of fixed-function counters. It keeps the chip-wide counting controls in one place: a 64-bit global enable map, a packed control word for the fixed counters, and a 64-bit sticky overflow status map with a write-one-to-clear companion. It qualifies every counter's increment with its global enable bit, turns overflow pulses from the counters into status bits, and holds a level interrupt line while any overflow that asked for an interrupt remains uncleared.

The same unit serves counter reads. A 32-bit read index picks the bank and the read width; the selected counter value comes back one cycle later, either at full width or cut to its low 32 bits. An index past the end of the chosen bank returns zero with an error flag. Fixed counter 0 is fed by the retired-instruction strobe, fixed counter 1 by the core-cycle strobe and fixed counter 2 by the reference-cycle strobe; the counters themselves live outside.

Top module: `ctrbank_gctl`

## Requirements
- R1: In the global enable and overflow status maps, general counter n owns bit n and fixed counter n owns bit 32+n; every other bit is held at zero, so writing all ones to the global enable register reads back 64'h0000_0007_0000_000F with four general and three fixed counters.
- R2: A general counter's count enable output is high only while both its local enable input and its global enable bit are set.
- R3: Each fixed counter n has a 4-bit field at bits 4n+3..4n of the fixed control register: bit 0 allows counting while cpu_user is 0, bit 1 allows counting while cpu_user is 1, bit 3 requests an interrupt on overflow, and bit 2 is reserved and always reads 0. The fixed increment output is the counter's event strobe qualified by its global enable bit and the mode bit matching cpu_user.
- R4: An overflow pulse sets its status bit on the next clock edge whether or not an interrupt was requested, and the bit stays set until cleared.
- R5: Register writes use wr_sel 0 for global enable, 1 for fixed control and 2 for overflow clear; a write with wr_sel 2 clears exactly the status bits written as one, an overflow arriving in the same cycle as the clear of its bit leaves the bit set, and wr_sel 3 changes no register.
- R6: irq rises the cycle after an overflow only when that counter requested an interrupt (gen_int_en for a general counter, control bit 3 for a fixed counter); an overflow without the request raises no interrupt.
- R7: irq stays high until every status bit whose overflow requested an interrupt has been cleared.
- R8: A read request samples rd_idx; one cycle later rd_vld is high with the data. rd_idx bit 30 selects the fixed bank and bit 31 selects fast mode, which returns the low 32 bits zero-extended; otherwise the full counter value is returned zero-extended to 64 bits.
- R9: When rd_idx bits 29..0 are not below the number of counters in the selected bank, the read returns zero with rd_err high.
- R10: After reset the global enable, fixed control and status registers are zero and irq and rd_vld are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 enable, 1 fixed control, 2 overflow clear |
| wr_data | input | 64 | Write data |
| glb_en | output | 64 | Global enable map |
| fix_ctl | output | 4*NUM_FIX | Fixed counter control fields |
| ovf_sts | output | 64 | Sticky overflow status map |
| gen_local_en | input | NUM_GEN | Local enables of the general counters |
| gen_int_en | input | NUM_GEN | Interrupt-on-overflow request of each general counter |
| gen_cnt_en | output | NUM_GEN | Qualified count enable per general counter |
| cpu_user | input | 1 | 1 while the processor runs in user mode |
| fix_evt | input | NUM_FIX | Event strobes: instructions, core cycles, reference cycles |
| fix_inc | output | NUM_FIX | Qualified increment per fixed counter |
| gen_ovf | input | NUM_GEN | Overflow pulses from the general counters |
| fix_ovf | input | NUM_FIX | Overflow pulses from the fixed counters |
| irq | output | 1 | Level interrupt request |
| rd_req | input | 1 | Counter read request |
| rd_idx | input | 32 | Read index with bank and width bits |
| gen_cnt_val | input | NUM_GEN*GEN_W | Packed general counter values |
| fix_cnt_val | input | NUM_FIX*FIX_W | Packed fixed counter values |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| rd_err | output | 1 | Read index out of range |

## Verification
A corrupted enable or control bit shows at once on gen_cnt_en or fix_inc in the same cycle, and the register outputs expose it one cycle after the write. A lost or wrongly kept status or pending bit shows on ovf_sts and irq one cycle after the overflow pulse or the clear write, which is where the bench samples. A decode error in the read path appears on rd_data and rd_err exactly one cycle after the request, and the scoreboard compares each response against the value it predicted from the index and the counter values it drove.

// File: rtl/ctrbank_pkg.sv
package ctrbank_pkg;

   typedef enum logic [1:0] {
      SEL_GLB_EN  = 2'd0,
      SEL_FIX_CTL = 2'd1,
      SEL_OVF_CLR = 2'd2,
      SEL_NONE    = 2'd3
   } reg_sel_e;

   localparam int MAP_W     = 64;
   localparam int FIX_BASE  = 32;
   localparam int NIB_W     = 4;
   localparam int NIB_KERN  = 0;
   localparam int NIB_USER  = 1;
   localparam int NIB_PMI   = 3;
   localparam logic [NIB_W-1:0] NIB_WMASK = 4'b1011;

   localparam int IDX_FIX_BIT  = 30;
   localparam int IDX_FAST_BIT = 31;
   localparam int IDX_NUM_W    = 30;

   function automatic logic [MAP_W-1:0] impl_mask(input int ng, input int nf);
      logic [MAP_W-1:0] m;
      m = '0;
      for (int i = 0; i < MAP_W; i++) begin
         if (i < ng || (i >= FIX_BASE && i < FIX_BASE + nf)) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ctrbank_regs.sv
module ctrbank_regs
   import ctrbank_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [MAP_W-1:0]         wr_data,
   output logic [MAP_W-1:0]         glb_en,
   output logic [NIB_W*NUM_FIX-1:0] fix_ctl,
   output logic [MAP_W-1:0]         clr_mask
);

   localparam int FCW = NIB_W * NUM_FIX;
   localparam logic [MAP_W-1:0] IMPL = impl_mask(NUM_GEN, NUM_FIX);
   localparam logic [FCW-1:0]   FMASK = {NUM_FIX{NIB_WMASK}};

   reg_sel_e          sel;
   logic [MAP_W-1:0]  glb_q;
   logic [FCW-1:0]    fix_q;

   assign sel = reg_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q <= '0;
         fix_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_GLB_EN:  glb_q <= wr_data & IMPL;
            SEL_FIX_CTL: fix_q <= wr_data[FCW-1:0] & FMASK;
            default:     ;
         endcase
      end
   end

   always_comb begin
      clr_mask = '0;
      if (wr_en && sel == SEL_OVF_CLR) clr_mask = wr_data & IMPL;
   end

   assign glb_en  = glb_q;
   assign fix_ctl = fix_q;

endmodule

// File: rtl/ctrbank_gate.sv
module ctrbank_gate #(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3
) (
   input  logic [NUM_GEN-1:0] glb_gen,
   input  logic [NUM_FIX-1:0] glb_fix,
   input  logic [NUM_GEN-1:0] gen_local_en,
   input  logic [NUM_FIX-1:0] fix_kern_en,
   input  logic [NUM_FIX-1:0] fix_user_en,
   input  logic [NUM_FIX-1:0] fix_evt,
   input  logic               cpu_user,
   output logic [NUM_GEN-1:0] gen_cnt_en,
   output logic [NUM_FIX-1:0] fix_inc
);

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      assign gen_cnt_en[g] = gen_local_en[g] & glb_gen[g];
   end

   for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
      logic mode_ok;
      assign mode_ok    = cpu_user ? fix_user_en[f] : fix_kern_en[f];
      assign fix_inc[f] = fix_evt[f] & glb_fix[f] & mode_ok;
   end

endmodule

// File: rtl/ctrbank_ovf.sv
module ctrbank_ovf
   import ctrbank_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_GEN-1:0] gen_ovf,
   input  logic [NUM_FIX-1:0] fix_ovf,
   input  logic [NUM_GEN-1:0] gen_int_en,
   input  logic [NUM_FIX-1:0] fix_pmi_en,
   input  logic [MAP_W-1:0]   clr_mask,
   output logic [MAP_W-1:0]   ovf_sts,
   output logic               irq
);

   logic [MAP_W-1:0] set_vec;
   logic [MAP_W-1:0] req_vec;
   logic [MAP_W-1:0] sts_q;
   logic [MAP_W-1:0] pend_q;

   always_comb begin
      set_vec = '0;
      req_vec = '0;
      set_vec[NUM_GEN-1:0]          = gen_ovf;
      set_vec[FIX_BASE +: NUM_FIX]  = fix_ovf;
      req_vec[NUM_GEN-1:0]          = gen_ovf & gen_int_en;
      req_vec[FIX_BASE +: NUM_FIX]  = fix_ovf & fix_pmi_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q  <= '0;
         pend_q <= '0;
      end else begin
         sts_q  <= (sts_q  & ~clr_mask) | set_vec;
         pend_q <= (pend_q & ~clr_mask) | req_vec;
      end
   end

   assign ovf_sts = sts_q;
   assign irq     = |pend_q;

endmodule

// File: rtl/ctrbank_rdmux.sv
module ctrbank_rdmux
   import ctrbank_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3,
   parameter int GEN_W   = 48,
   parameter int FIX_W   = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_req,
   input  logic [31:0]              rd_idx,
   input  logic [NUM_GEN*GEN_W-1:0] gen_cnt_val,
   input  logic [NUM_FIX*FIX_W-1:0] fix_cnt_val,
   output logic                     rd_vld,
   output logic [MAP_W-1:0]         rd_data,
   output logic                     rd_err
);

   logic [MAP_W-1:0]     gen_ext [NUM_GEN];
   logic [MAP_W-1:0]     fix_ext [NUM_FIX];
   logic [IDX_NUM_W-1:0] idx_num;
   logic                 want_fix;
   logic                 want_fast;
   logic                 hit;
   logic [MAP_W-1:0]     sel_val;
   logic [MAP_W-1:0]     shaped;

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gext
      if (GEN_W == MAP_W) begin : g_full
         assign gen_ext[g] = gen_cnt_val[g*GEN_W +: GEN_W];
      end else begin : g_pad
         assign gen_ext[g] = {{(MAP_W-GEN_W){1'b0}}, gen_cnt_val[g*GEN_W +: GEN_W]};
      end
   end

   for (genvar f = 0; f < NUM_FIX; f++) begin : g_fext
      if (FIX_W == MAP_W) begin : g_full
         assign fix_ext[f] = fix_cnt_val[f*FIX_W +: FIX_W];
      end else begin : g_pad
         assign fix_ext[f] = {{(MAP_W-FIX_W){1'b0}}, fix_cnt_val[f*FIX_W +: FIX_W]};
      end
   end

   assign idx_num   = rd_idx[IDX_NUM_W-1:0];
   assign want_fix  = rd_idx[IDX_FIX_BIT];
   assign want_fast = rd_idx[IDX_FAST_BIT];

   always_comb begin
      sel_val = '0;
      hit     = 1'b0;
      for (int i = 0; i < NUM_GEN; i++) begin
         if (!want_fix && idx_num == IDX_NUM_W'(i)) begin
            sel_val = gen_ext[i];
            hit     = 1'b1;
         end
      end
      for (int i = 0; i < NUM_FIX; i++) begin
         if (want_fix && idx_num == IDX_NUM_W'(i)) begin
            sel_val = fix_ext[i];
            hit     = 1'b1;
         end
      end
   end

   always_comb begin
      if (!hit)          shaped = '0;
      else if (want_fast) shaped = {32'b0, sel_val[31:0]};
      else               shaped = sel_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
         rd_err  <= 1'b0;
      end else begin
         rd_vld  <= rd_req;
         rd_data <= rd_req ? shaped : '0;
         rd_err  <= rd_req & ~hit;
      end
   end

endmodule

// File: rtl/ctrbank_gctl.sv
module ctrbank_gctl
   import ctrbank_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3,
   parameter int GEN_W   = 48,
   parameter int FIX_W   = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_sel,
   input  logic [63:0]              wr_data,
   output logic [63:0]              glb_en,
   output logic [4*NUM_FIX-1:0]     fix_ctl,
   output logic [63:0]              ovf_sts,
   input  logic [NUM_GEN-1:0]       gen_local_en,
   input  logic [NUM_GEN-1:0]       gen_int_en,
   output logic [NUM_GEN-1:0]       gen_cnt_en,
   input  logic                     cpu_user,
   input  logic [NUM_FIX-1:0]       fix_evt,
   output logic [NUM_FIX-1:0]       fix_inc,
   input  logic [NUM_GEN-1:0]       gen_ovf,
   input  logic [NUM_FIX-1:0]       fix_ovf,
   output logic                     irq,
   input  logic                     rd_req,
   input  logic [31:0]              rd_idx,
   input  logic [NUM_GEN*GEN_W-1:0] gen_cnt_val,
   input  logic [NUM_FIX*FIX_W-1:0] fix_cnt_val,
   output logic                     rd_vld,
   output logic [63:0]              rd_data,
   output logic                     rd_err
);

   if (NUM_GEN < 1 || NUM_GEN > 32) begin : g_chk_ngen
      $error("NUM_GEN must lie in 1..32");
   end
   if (NUM_FIX < 1 || NUM_FIX > 16) begin : g_chk_nfix
      $error("NUM_FIX must lie in 1..16 so the control fields fit the write bus");
   end
   if (GEN_W < 32 || GEN_W > 64) begin : g_chk_gw
      $error("GEN_W must lie in 32..64");
   end
   if (FIX_W < 32 || FIX_W > 64) begin : g_chk_fw
      $error("FIX_W must lie in 32..64");
   end

   logic [MAP_W-1:0]   clr_mask;
   logic [NUM_FIX-1:0] fix_kern_en;
   logic [NUM_FIX-1:0] fix_user_en;
   logic [NUM_FIX-1:0] fix_pmi_en;

   ctrbank_regs #(
      .NUM_GEN (NUM_GEN),
      .NUM_FIX (NUM_FIX)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .glb_en   (glb_en),
      .fix_ctl  (fix_ctl),
      .clr_mask (clr_mask)
   );

   for (genvar f = 0; f < NUM_FIX; f++) begin : g_field
      assign fix_kern_en[f] = fix_ctl[NIB_W*f + NIB_KERN];
      assign fix_user_en[f] = fix_ctl[NIB_W*f + NIB_USER];
      assign fix_pmi_en[f]  = fix_ctl[NIB_W*f + NIB_PMI];
   end

   ctrbank_gate #(
      .NUM_GEN (NUM_GEN),
      .NUM_FIX (NUM_FIX)
   ) u_gate (
      .glb_gen      (glb_en[NUM_GEN-1:0]),
      .glb_fix      (glb_en[FIX_BASE +: NUM_FIX]),
      .gen_local_en (gen_local_en),
      .fix_kern_en  (fix_kern_en),
      .fix_user_en  (fix_user_en),
      .fix_evt      (fix_evt),
      .cpu_user     (cpu_user),
      .gen_cnt_en   (gen_cnt_en),
      .fix_inc      (fix_inc)
   );

   ctrbank_ovf #(
      .NUM_GEN (NUM_GEN),
      .NUM_FIX (NUM_FIX)
   ) u_ovf (
      .clk        (clk),
      .rst_n      (rst_n),
      .gen_ovf    (gen_ovf),
      .fix_ovf    (fix_ovf),
      .gen_int_en (gen_int_en),
      .fix_pmi_en (fix_pmi_en),
      .clr_mask   (clr_mask),
      .ovf_sts    (ovf_sts),
      .irq        (irq)
   );

   ctrbank_rdmux #(
      .NUM_GEN (NUM_GEN),
      .NUM_FIX (NUM_FIX),
      .GEN_W   (GEN_W),
      .FIX_W   (FIX_W)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_req      (rd_req),
      .rd_idx      (rd_idx),
      .gen_cnt_val (gen_cnt_val),
      .fix_cnt_val (fix_cnt_val),
      .rd_vld      (rd_vld),
      .rd_data     (rd_data),
      .rd_err      (rd_err)
   );

endmodule

// File: rtl/ctrbank_gctl_chk.sv
module ctrbank_gctl_chk
   import ctrbank_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_sel,
   input logic [63:0]        glb_en,
   input logic [63:0]        ovf_sts,
   input logic [NUM_GEN-1:0] gen_local_en,
   input logic [NUM_GEN-1:0] gen_cnt_en,
   input logic [NUM_GEN-1:0] gen_ovf,
   input logic [NUM_FIX-1:0] fix_ovf,
   input logic               irq,
   input logic               rd_req,
   input logic [31:0]        rd_idx,
   input logic               rd_vld,
   input logic [63:0]        rd_data,
   input logic               rd_err
);

   localparam logic [63:0] IMPL = impl_mask(NUM_GEN, NUM_FIX);

   // R1: holes in the maps never carry a one
   a_r1_map_holes: assert property (@(posedge clk) disable iff (!rst_n)
      ((glb_en & ~IMPL) == '0) && ((ovf_sts & ~IMPL) == '0));

   // R2: no count enable without both local and global permission
   a_r2_gen_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_cnt_en & ~(gen_local_en & glb_en[NUM_GEN-1:0])) == '0);

   // R4: a general overflow pulse shows in status on the next edge
   a_r4_gen_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|gen_ovf) |=> ((ovf_sts[NUM_GEN-1:0] & $past(gen_ovf)) == $past(gen_ovf)));

   // R4: a fixed overflow pulse shows in status on the next edge
   a_r4_fix_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|fix_ovf) |=> ((ovf_sts[FIX_BASE +: NUM_FIX] & $past(fix_ovf)) == $past(fix_ovf)));

   // R5: without a clear write no status bit falls
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == 2'd2) |=> ((ovf_sts & $past(ovf_sts)) == $past(ovf_sts)));

   // R7: the interrupt never stands without a recorded overflow
   a_r7_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_sts != '0));

   // R8: a request is answered on the following cycle
   a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_vld);

   // R8: a fast read never returns upper bits
   a_r8_fast_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_idx[IDX_FAST_BIT]) |=> (rd_data[63:32] == 32'b0));

   // R9: an error response carries zero data
   a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_vld && rd_data == '0));

endmodule

bind ctrbank_gctl ctrbank_gctl_chk #(
   .NUM_GEN (NUM_GEN),
   .NUM_FIX (NUM_FIX)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .glb_en       (glb_en),
   .ovf_sts      (ovf_sts),
   .gen_local_en (gen_local_en),
   .gen_cnt_en   (gen_cnt_en),
   .gen_ovf      (gen_ovf),
   .fix_ovf      (fix_ovf),
   .irq          (irq),
   .rd_req       (rd_req),
   .rd_idx       (rd_idx),
   .rd_vld       (rd_vld),
   .rd_data      (rd_data),
   .rd_err       (rd_err)
);

// File: tb/test_ctrbank_gctl.sv
`timescale 1ns/1ps
module test_ctrbank_gctl;

   localparam int NG = 4;
   localparam int NF = 3;
   localparam int GW = 48;
   localparam int FW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [63:0]   wr_data = '0;
   logic [63:0]   glb_en;
   logic [4*NF-1:0] fix_ctl;
   logic [63:0]   ovf_sts;
   logic [NG-1:0] gen_local_en = '0;
   logic [NG-1:0] gen_int_en = '0;
   logic [NG-1:0] gen_cnt_en;
   logic          cpu_user = 1'b0;
   logic [NF-1:0] fix_evt = '0;
   logic [NF-1:0] fix_inc;
   logic [NG-1:0] gen_ovf = '0;
   logic [NF-1:0] fix_ovf = '0;
   logic          irq;
   logic          rd_req = 1'b0;
   logic [31:0]   rd_idx = '0;
   logic [NG*GW-1:0] gen_cnt_val = '0;
   logic [NF*FW-1:0] fix_cnt_val = '0;
   logic          rd_vld;
   logic [63:0]   rd_data;
   logic          rd_err;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      logic [63:0] data;
      logic        err;
      string       req;
   } rd_exp_t;
   rd_exp_t sb_q[$];

   always #2.5 clk = ~clk;

   ctrbank_gctl #(.NUM_GEN(NG), .NUM_FIX(NF), .GEN_W(GW), .FIX_W(FW)) i_ctrbank_gctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .glb_en(glb_en), .fix_ctl(fix_ctl), .ovf_sts(ovf_sts),
      .gen_local_en(gen_local_en), .gen_int_en(gen_int_en), .gen_cnt_en(gen_cnt_en),
      .cpu_user(cpu_user), .fix_evt(fix_evt), .fix_inc(fix_inc),
      .gen_ovf(gen_ovf), .fix_ovf(fix_ovf), .irq(irq),
      .rd_req(rd_req), .rd_idx(rd_idx), .gen_cnt_val(gen_cnt_val), .fix_cnt_val(fix_cnt_val),
      .rd_vld(rd_vld), .rd_data(rd_data), .rd_err(rd_err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [63:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input logic [NG-1:0] g, input logic [NF-1:0] f);
      gen_ovf = g; fix_ovf = f;
      @(negedge clk);
      gen_ovf = '0; fix_ovf = '0;
   endtask

   // driver: predicts the response and queues it, then issues the request
   task automatic rd(input string req, input logic [31:0] idx,
                     input logic [63:0] exp_d, input logic exp_e);
      rd_exp_t e;
      e.data = exp_d; e.err = exp_e; e.req = req;
      sb_q.push_back(e);
      rd_req = 1'b1; rd_idx = idx;
      @(negedge clk);
      rd_req = 1'b0; rd_idx = '0;
   endtask

   // monitor: pops one prediction per valid response
   always @(negedge clk) begin
      if (rst_n && rd_vld) begin
         if (sb_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R8: actual unexpected response %h expected none", rd_data);
         end else begin
            rd_exp_t e;
            e = sb_q.pop_front();
            chk({e.req, " data"}, rd_data, e.data);
            chk({e.req, " err"}, {63'b0, rd_err}, {63'b0, e.err});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] glb_exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 glb_en", glb_en, 64'h0);
      chk("R10 fix_ctl", 64'(fix_ctl), 64'h0);
      chk("R10 ovf_sts", ovf_sts, 64'h0);
      chk("R10 irq/rd_vld", {62'b0, irq, rd_vld}, 64'h0);

      // R1 only implemented bits stick
      wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R1 enable map", glb_en, 64'h0000_0007_0000_000F);

      // R2 gating patterns
      gen_local_en = 4'b1010; #1;
      chk("R2 all global", 64'(gen_cnt_en), 64'hA);
      wr(2'd0, 64'h6); gen_local_en = 4'b1010; #1;
      chk("R2 partial global", 64'(gen_cnt_en), 64'h2);
      gen_local_en = 4'b0101; #1;
      chk("R2 other local", 64'(gen_cnt_en), 64'h4);

      // R3 reserved bit and mode qualification
      wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R3 reserved bit zero", 64'(fix_ctl), 64'hBBB);
      wr(2'd1, 64'h321);
      glb_exp = 64'h7_0000_0006;
      wr(2'd0, glb_exp);
      chk("R1 fixed enable bits", glb_en, glb_exp);
      fix_evt = 3'b111; cpu_user = 1'b0; #1;
      chk("R3 kernel mode", 64'(fix_inc), 64'h5);
      cpu_user = 1'b1; #1;
      chk("R3 user mode", 64'(fix_inc), 64'h6);
      glb_exp = 64'h5_0000_0006;
      wr(2'd0, glb_exp); #1;
      chk("R3 global bit 33 off", 64'(fix_inc), 64'h4);
      fix_evt = 3'b010; #1;
      chk("R3 strobe needed", 64'(fix_inc), 64'h0);
      fix_evt = '0;

      // R4 R6 overflow without request
      wr(2'd1, 64'h329);
      gen_int_en = 4'b0100;
      pulse(4'b0010, 3'b000);
      chk("R4 status without request", ovf_sts, 64'h2);
      chk("R6 no irq without request", {63'b0, irq}, 64'h0);
      pulse(4'b0000, 3'b001);
      chk("R4 fixed status", ovf_sts, 64'h1_0000_0002);
      chk("R6 fixed request raises irq", {63'b0, irq}, 64'h1);
      wr(2'd2, 64'h2);
      chk("R5 clear only written bit", ovf_sts, 64'h1_0000_0000);
      chk("R7 irq held", {63'b0, irq}, 64'h1);
      wr(2'd2, 64'h1_0000_0000);
      chk("R5 clear fixed bit", ovf_sts, 64'h0);
      chk("R7 irq dropped", {63'b0, irq}, 64'h0);

      pulse(4'b0100, 3'b000);
      chk("R6 general request raises irq", {63'b0, irq}, 64'h1);
      pulse(4'b0000, 3'b010);
      chk("R4 second status", ovf_sts, 64'h2_0000_0004);
      wr(2'd2, 64'h2_0000_0000);
      chk("R7 irq held by general bit", {63'b0, irq}, 64'h1);
      wr(2'd2, 64'h4);
      chk("R7 irq released", {63'b0, irq}, 64'h0);
      chk("R5 all clear", ovf_sts, 64'h0);

      // R5 set wins over same-cycle clear
      gen_ovf = 4'b0001; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 64'h1;
      @(negedge clk);
      gen_ovf = '0; wr_en = 1'b0; wr_data = '0;
      chk("R5 set beats clear", ovf_sts, 64'h1);

      // R5 select 3 changes nothing
      wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R5 sel3 enable", glb_en, glb_exp);
      chk("R5 sel3 fixed ctl", 64'(fix_ctl), 64'h329);
      chk("R5 sel3 status", ovf_sts, 64'h1);
      wr(2'd2, 64'h1);
      chk("R5 final clear", ovf_sts, 64'h0);

      // R8 R9 reads
      gen_cnt_val[0*GW +: GW] = 48'h0000_0000_0042;
      gen_cnt_val[1*GW +: GW] = 48'hABCD_1234_5678;
      gen_cnt_val[3*GW +: GW] = 48'hFFFF_FFFF_FFFF;
      fix_cnt_val[0*FW +: FW] = 48'h0000_0000_0007;
      fix_cnt_val[2*FW +: FW] = 48'h8000_0000_0001;
      rd("R8 general full", 32'h0000_0001, 64'h0000_ABCD_1234_5678, 1'b0);
      rd("R8 general fast", 32'h8000_0001, 64'h0000_0000_1234_5678, 1'b0);
      rd("R8 fixed full", 32'h4000_0002, 64'h0000_8000_0000_0001, 1'b0);
      rd("R8 fixed fast", 32'hC000_0002, 64'h1, 1'b0);
      rd("R8 general top", 32'h0000_0003, 64'h0000_FFFF_FFFF_FFFF, 1'b0);
      rd("R8 fixed zero", 32'h4000_0000, 64'h7, 1'b0);
      rd("R9 general past end", 32'h0000_0004, 64'h0, 1'b1);
      rd("R9 fixed past end", 32'h4000_0003, 64'h0, 1'b1);
      rd("R9 high index", 32'h2000_0000, 64'h0, 1'b1);
      rd("R8 general zero", 32'h0000_0000, 64'h42, 1'b0);
      repeat (3) @(negedge clk);
      chk("R8 all responses seen", 64'(sb_q.size()), 64'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule